// File: doc/BRIEF.md
# ULPI Link Startup Reset Sequencer

This block sits on the link side of a ULPI connection and runs in the 60 MHz ULPI clock domain. It takes the PHY from power-up to a state where USB traffic may start. It waits for the PHY to release the shared data bus and drives the bus to the all-zeros idle value. It ignores every receive command the PHY sends before the link has reset it. It then issues one register write that sets the self-clearing reset bit of the PHY's function-control register. It waits for the PHY to raise and then drop the bus direction around its internal reset, and takes the next receive command as the first valid line status.

The sequencer tracks the direction line, so every change of direction is followed by one turnaround cycle in which nothing is sampled. If the PHY takes the bus back in the middle of the register write, the write is abandoned and restarted from the command byte once the bus is free again. When the post-reset status byte has been captured, a sticky ready flag goes high. Each wait for the PHY to move the direction line is guarded by a cycle counter that raises a sticky timeout flag.

Top module: `ulpi_startup_seq`

## Requirements
- R1: After reset the outputs are: ready low, timeout flag low, stop strobe low, link data value 0x00.
- R2: The link drives the data bus (output enable high) exactly when the PHY's direction input is low, and never while it is high.
- R3: While it waits for the PHY and before the write starts, the link drives 0x00 on the bus.
- R4: Receive commands that arrive before the reset write completes change neither the ready flag nor the captured status.
- R5: The register write puts the command byte 0x84 (code 2'b10 in bits 7:6, address 0x04 in bits 5:0) on the bus and holds it until NXT is high, then holds the data byte 0x20 (bit 5 set) until NXT is high again.
- R6: In the cycle after the data byte is accepted, the stop strobe is high for exactly one cycle with the bus value 0x00.
- R7: If DIR rises while the command or data byte is pending, the write is abandoned and, after DIR falls, starts again from the command byte.
- R8: The first cycle after any DIR change is a turnaround cycle: a byte present on the bus in that cycle is never captured.
- R9: After the write, the block waits for DIR to rise and then fall, then captures bits 1:0 (line state) and 3:2 (VBUS state) of the next receive command (DIR high, NXT low, not a turnaround) and raises ready one cycle later; ready and the captured values then stay fixed.
- R10: If the block stays in a state that waits for DIR to change for TIMEOUT_CYCLES cycles, the timeout flag goes high and stays high; short waits leave it low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | ULPI clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| phy_dir | input | 1 | Bus direction from the PHY, high when the PHY owns the bus |
| phy_nxt | input | 1 | PHY throttle; accepts a link byte when high |
| phy_data_in | input | 8 | Bus value driven by the PHY |
| link_data_out | output | 8 | Bus value driven by the link |
| link_data_oe | output | 1 | Link output enable for the data bus |
| link_stp | output | 1 | Stop strobe toward the PHY |
| ready | output | 1 | Sticky: startup finished |
| line_state | output | 2 | Captured line-state bits of the post-reset status |
| vbus_state | output | 2 | Captured VBUS bits of the post-reset status |
| timeout_err | output | 1 | Sticky: a wait for DIR ran out |

## Verification
The case that is hardest to reach is a write interrupted by the PHY. The bench has to take back the bus exactly while the command byte or the data byte is pending, and then check that the link starts again at the command byte and not at the data byte. The PHY model raises DIR at cycle-exact points in both write phases and sends status bytes that must be discarded. A scoreboard queue records which bytes the link should present at each NXT handshake. The turnaround rule is covered by putting a different status byte in the first DIR-high cycle after the reset, so that taking the wrong cycle gives a different captured value.

// File: rtl/ulpi_seq_pkg.sv
package ulpi_seq_pkg;

  typedef enum logic [3:0] {
    ST_WAIT_PHY,
    ST_IDLE_DRIVE,
    ST_WRITE_CMD,
    ST_WRITE_DATA,
    ST_STOP,
    ST_WAIT_RST_HI,
    ST_WAIT_RST_LO,
    ST_WAIT_RXCMD,
    ST_READY
  } seq_state_e;

  localparam int unsigned BUS_W = 8;
  localparam logic [1:0]  TXCMD_REG_WRITE = 2'b10;

  function automatic logic [BUS_W-1:0] reg_write_cmd(input logic [5:0] addr);
    return {TXCMD_REG_WRITE, addr};
  endfunction

  function automatic logic [BUS_W-1:0] one_hot_byte(input int unsigned pos);
    logic [BUS_W-1:0] v;
    v = '0;
    v[pos] = 1'b1;
    return v;
  endfunction

  function automatic logic is_dir_wait(input seq_state_e s);
    return (s == ST_WAIT_PHY) || (s == ST_WAIT_RST_HI) ||
           (s == ST_WAIT_RST_LO) || (s == ST_WAIT_RXCMD);
  endfunction

endpackage

// File: rtl/ulpi_dir_track.sv
module ulpi_dir_track (
  input  logic clk,
  input  logic rst_n,
  input  logic dir,
  output logic turn
);
  logic dir_q;

  // PHY holds the bus at power-up, so the tracked value starts high
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) dir_q <= 1'b1;
    else        dir_q <= dir;
  end

  assign turn = dir ^ dir_q;
endmodule

// File: rtl/ulpi_startup_fsm.sv
module ulpi_startup_fsm
  import ulpi_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       dir,
  input  logic       nxt,
  input  logic       turn,
  input  logic [3:0] status_in,
  output seq_state_e state,
  output logic       state_change,
  output logic [1:0] line_state,
  output logic [1:0] vbus_state
);
  seq_state_e state_q, state_d;
  logic       cap_en;
  logic [1:0] line_q, vbus_q;

  always_comb begin
    state_d = state_q;
    cap_en  = 1'b0;
    unique case (state_q)
      ST_WAIT_PHY:    if (!dir && !turn) state_d = ST_IDLE_DRIVE;
      ST_IDLE_DRIVE:  if (!dir && !turn) state_d = ST_WRITE_CMD;
      ST_WRITE_CMD: begin
        if (dir)      state_d = ST_IDLE_DRIVE;
        else if (nxt) state_d = ST_WRITE_DATA;
      end
      ST_WRITE_DATA: begin
        if (dir)      state_d = ST_IDLE_DRIVE;
        else if (nxt) state_d = ST_STOP;
      end
      ST_STOP:        state_d = ST_WAIT_RST_HI;
      ST_WAIT_RST_HI: if (dir)  state_d = ST_WAIT_RST_LO;
      ST_WAIT_RST_LO: if (!dir) state_d = ST_WAIT_RXCMD;
      ST_WAIT_RXCMD: begin
        if (dir && !turn && !nxt) begin
          cap_en  = 1'b1;
          state_d = ST_READY;
        end
      end
      ST_READY:       state_d = ST_READY;
      default:        state_d = ST_WAIT_PHY;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_WAIT_PHY;
    else        state_q <= state_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      line_q <= 2'b00;
      vbus_q <= 2'b00;
    end else if (cap_en) begin
      line_q <= status_in[1:0];
      vbus_q <= status_in[3:2];
    end
  end

  assign state        = state_q;
  assign state_change = (state_d != state_q);
  assign line_state   = line_q;
  assign vbus_state   = vbus_q;
endmodule

// File: rtl/ulpi_tx_drive.sv
module ulpi_tx_drive
  import ulpi_seq_pkg::*;
#(
  parameter logic [5:0]  FUNC_ADDR     = 6'h04,
  parameter int unsigned RESET_BIT_POS = 5
) (
  input  seq_state_e       state,
  output logic [BUS_W-1:0] data_out,
  output logic             stp
);
  localparam logic [BUS_W-1:0] CMD_BYTE  = reg_write_cmd(FUNC_ADDR);
  localparam logic [BUS_W-1:0] DATA_BYTE = one_hot_byte(RESET_BIT_POS);

  always_comb begin
    data_out = '0;
    stp      = 1'b0;
    case (state)
      ST_WRITE_CMD:  data_out = CMD_BYTE;
      ST_WRITE_DATA: data_out = DATA_BYTE;
      ST_STOP:       stp      = 1'b1;
      default:       data_out = '0;
    endcase
  end
endmodule

// File: rtl/ulpi_wait_timer.sv
module ulpi_wait_timer #(
  parameter int unsigned LIMIT = 4096
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic clear,
  output logic expired
);
  localparam int unsigned CW = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] TOP = CW'(LIMIT);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;
  logic          err_q;

  assign cnt_en = clear || (run && (cnt_q != TOP));
  assign cnt_d  = clear ? '0 : cnt_q + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              err_q <= 1'b0;
    else if (cnt_q == TOP)   err_q <= 1'b1;
  end

  assign expired = err_q;
endmodule

// File: rtl/ulpi_startup_seq.sv
module ulpi_startup_seq
  import ulpi_seq_pkg::*;
#(
  parameter int unsigned TIMEOUT_CYCLES = 4096,
  parameter logic [5:0]  FUNC_ADDR      = 6'h04,
  parameter int unsigned RESET_BIT_POS  = 5
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       phy_dir,
  input  logic       phy_nxt,
  input  logic [7:0] phy_data_in,
  output logic [7:0] link_data_out,
  output logic       link_data_oe,
  output logic       link_stp,
  output logic       ready,
  output logic [1:0] line_state,
  output logic [1:0] vbus_state,
  output logic       timeout_err
);
  logic [1:0] rst_sync_q;
  logic       rst_core_n;
  logic       turn;
  logic       state_change;
  seq_state_e state;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_core_n = rst_sync_q[1];

  ulpi_dir_track i_dir (
    .clk   (clk),
    .rst_n (rst_core_n),
    .dir   (phy_dir),
    .turn  (turn)
  );

  ulpi_startup_fsm i_fsm (
    .clk          (clk),
    .rst_n        (rst_core_n),
    .dir          (phy_dir),
    .nxt          (phy_nxt),
    .turn         (turn),
    .status_in    (phy_data_in[3:0]),
    .state        (state),
    .state_change (state_change),
    .line_state   (line_state),
    .vbus_state   (vbus_state)
  );

  ulpi_tx_drive #(
    .FUNC_ADDR     (FUNC_ADDR),
    .RESET_BIT_POS (RESET_BIT_POS)
  ) i_tx (
    .state    (state),
    .data_out (link_data_out),
    .stp      (link_stp)
  );

  ulpi_wait_timer #(
    .LIMIT (TIMEOUT_CYCLES)
  ) i_timer (
    .clk     (clk),
    .rst_n   (rst_core_n),
    .run     (is_dir_wait(state)),
    .clear   (state_change),
    .expired (timeout_err)
  );

  assign link_data_oe = ~phy_dir;
  assign ready        = (state == ST_READY);
endmodule

// File: rtl/ulpi_startup_seq_chk.sv
module ulpi_startup_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       phy_dir,
  input logic       phy_nxt,
  input logic [7:0] link_data_out,
  input logic       link_data_oe,
  input logic       link_stp,
  input logic       ready,
  input logic [1:0] line_state,
  input logic [1:0] vbus_state,
  input logic       timeout_err
);
  a_r2_no_drive_when_phy_owns: assert property (@(posedge clk) disable iff (!rst_n)
    phy_dir |-> !link_data_oe);

  a_r5_cmd_held: assert property (@(posedge clk) disable iff (!rst_n)
    (!phy_dir && !phy_nxt && link_data_out == 8'h84) |=> (link_data_out == 8'h84));

  a_r6_stp_after_data: assert property (@(posedge clk) disable iff (!rst_n)
    (!phy_dir && phy_nxt && link_data_out == 8'h20) |=> link_stp);

  a_r6_stp_single: assert property (@(posedge clk) disable iff (!rst_n)
    link_stp |=> !link_stp);

  a_r6_stp_idle_bus: assert property (@(posedge clk) disable iff (!rst_n)
    link_stp |-> (link_data_out == 8'h00));

  a_r9_ready_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    ready |=> ready);

  a_r9_status_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    ready |=> ($stable(line_state) && $stable(vbus_state)));

  a_r10_timeout_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    timeout_err |=> timeout_err);
endmodule

bind ulpi_startup_seq ulpi_startup_seq_chk i_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .phy_dir       (phy_dir),
  .phy_nxt       (phy_nxt),
  .link_data_out (link_data_out),
  .link_data_oe  (link_data_oe),
  .link_stp      (link_stp),
  .ready         (ready),
  .line_state    (line_state),
  .vbus_state    (vbus_state),
  .timeout_err   (timeout_err)
);

// File: tb/test_ulpi_startup_seq.sv
module test_ulpi_startup_seq;
  localparam int CLK_PERIOD = 10;
  localparam int TMO        = 64;

  logic       clk;
  logic       rst_n;
  logic       phy_dir;
  logic       phy_nxt;
  logic [7:0] phy_data_in;
  logic [7:0] link_data_out;
  logic       link_data_oe;
  logic       link_stp;
  logic       ready;
  logic [1:0] line_state;
  logic [1:0] vbus_state;
  logic       timeout_err;

  int total = 0;
  int bad   = 0;
  bit done  = 0;
  logic [7:0] exp_q[$];

  ulpi_startup_seq #(.TIMEOUT_CYCLES(TMO)) i_ulpi_startup_seq (
    .clk(clk), .rst_n(rst_n), .phy_dir(phy_dir), .phy_nxt(phy_nxt),
    .phy_data_in(phy_data_in), .link_data_out(link_data_out),
    .link_data_oe(link_data_oe), .link_stp(link_stp), .ready(ready),
    .line_state(line_state), .vbus_state(vbus_state), .timeout_err(timeout_err)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  // scoreboard monitor: every NXT handshake with the link owning the bus
  always @(negedge clk) begin
    if (rst_n && !phy_dir && phy_nxt) begin
      if (exp_q.size() == 0) check(1'b0, "R5 unexpected handshake", link_data_out, 0);
      else begin
        logic [7:0] e;
        e = exp_q.pop_front();
        check(link_data_out == e, "R5 handshake byte", link_data_out, e);
      end
    end
  end

  task automatic wait_cmd(output bit found);
    found = 0;
    for (int i = 0; i < 20 && !found; i++) begin
      @(negedge clk);
      if (link_data_oe && link_data_out == 8'h84) found = 1;
      @(posedge clk); #1;
    end
  endtask

  task automatic accept(input logic [7:0] e);
    exp_q.push_back(e);
    phy_nxt = 1'b1;
    step();
    phy_nxt = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    bit found;
    rst_n = 1'b0; phy_dir = 1'b1; phy_nxt = 1'b0; phy_data_in = 8'h2A;
    repeat (3) step();
    rst_n = 1'b1;
    @(negedge clk);
    check(!ready && !timeout_err && !link_stp && link_data_out == 8'h00, "R1 reset state",
          {ready, timeout_err, link_stp}, 0);
    // PHY holds the bus during power-up with status bytes on it
    repeat (4) step();
    @(negedge clk);
    check(!link_data_oe, "R2 no drive while DIR high", link_data_oe, 0);
    check(!ready, "R4 early status ignored", ready, 0);
    @(posedge clk); #1;
    phy_dir = 1'b0; phy_data_in = 8'h00;
    @(negedge clk);
    check(link_data_oe && link_data_out == 8'h00, "R3 idle drive", link_data_out, 0);
    @(posedge clk); #1;
    wait_cmd(found);
    check(found, "R5 command byte presented", found, 1);
    // PHY grabs the bus during the command byte: abort, early status to discard
    phy_dir = 1'b1; phy_data_in = 8'h0F;
    step();
    @(negedge clk);
    check(!link_data_oe && !link_stp, "R2 abort releases bus", link_data_oe, 0);
    @(posedge clk); #1;
    step();
    phy_dir = 1'b0; phy_data_in = 8'h00;
    wait_cmd(found);
    check(found, "R7 restart after cmd abort", found, 1);
    check(!ready, "R4 early status ignored after abort", ready, 0);
    accept(8'h84);
    @(negedge clk);
    check(link_data_out == 8'h20, "R5 data byte follows", link_data_out, 8'h20);
    // PHY grabs the bus during the data byte
    @(posedge clk); #1;
    phy_dir = 1'b1; phy_data_in = 8'h05;
    step(); step();
    phy_dir = 1'b0; phy_data_in = 8'h00;
    wait_cmd(found);
    check(found, "R7 restart from command after data abort", found, 1);
    accept(8'h84);
    @(negedge clk);
    check(link_data_out == 8'h20, "R5 data byte", link_data_out, 8'h20);
    @(posedge clk); #1;
    @(negedge clk);
    check(link_data_out == 8'h20 && !link_stp, "R5 data held without NXT", link_data_out, 8'h20);
    @(posedge clk); #1;
    accept(8'h20);
    @(negedge clk);
    check(link_stp && link_data_out == 8'h00, "R6 stop strobe", {link_stp, link_data_out}, 9'h100);
    @(posedge clk); #1;
    @(negedge clk);
    check(!link_stp, "R6 stop one cycle", link_stp, 0);
    check(exp_q.size() == 0, "R5 all handshakes seen", exp_q.size(), 0);
    @(posedge clk); #1;
    // PHY internal reset
    phy_dir = 1'b1; phy_data_in = 8'h2A;
    repeat (5) step();
    phy_dir = 1'b0; phy_data_in = 8'h00;
    step(); step();
    @(negedge clk);
    check(!ready, "R9 not ready before status", ready, 0);
    @(posedge clk); #1;
    phy_dir = 1'b1; phy_data_in = 8'h33;   // turnaround cycle
    step();
    phy_data_in = 8'h0E;                   // first valid status
    step();
    phy_dir = 1'b0; phy_data_in = 8'h00;
    @(negedge clk);
    check(ready, "R9 ready after status", ready, 1);
    check(line_state == 2'b10, "R8 R9 line state", line_state, 2'b10);
    check(vbus_state == 2'b11, "R8 R9 vbus state", vbus_state, 2'b11);
    @(posedge clk); #1;
    phy_dir = 1'b1; phy_data_in = 8'h01;
    step(); step(); step();
    phy_dir = 1'b0;
    step();
    @(negedge clk);
    check(ready && line_state == 2'b10 && vbus_state == 2'b11, "R9 status frozen",
          {ready, vbus_state, line_state}, 5'h1E);
    check(!timeout_err, "R10 no timeout on short waits", timeout_err, 0);
    // timeout: PHY never releases the bus
    @(posedge clk); #1;
    rst_n = 1'b0; phy_dir = 1'b1;
    step(); step();
    rst_n = 1'b1;
    repeat (30) step();
    @(negedge clk);
    check(!timeout_err, "R10 no early timeout", timeout_err, 0);
    @(posedge clk); #1;
    repeat (60) step();
    @(negedge clk);
    check(timeout_err, "R10 timeout raised", timeout_err, 1);
    check(!ready, "R10 stuck not ready", ready, 0);
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule